// File: doc/BRIEF.md
# Page-Load Buffer and Write Controller

This block is the synchronous front end of a byte-wide nonvolatile memory that is written one page at a time. The host writes bytes with ordinary chip-select and write strobes. The block gathers up to a page of bytes in a local buffer, and each byte lands at the offset given by the low address bits. A new byte is accepted only while it starts inside a byte window measured from the previous byte. When no accepted strobe starts for a load-timeout period, the block commits the page.

The commit does not need a command. It is an internal write of fixed length that cannot be interrupted, and `busy` is high for all of it. In its final cycles the block streams the whole page to a simple array write port, one byte per cycle, at ascending offsets. The target page is the page address of the last byte accepted, and every offset the host did not load goes out as FFh. An external command decoder gates loading through `loadAllowed`. All windows are parameters counted in clock cycles. The strobe inputs are expected to be synchronized already.

Top module: `page_load_writer`

## Requirements
- R1: After reset, `busy` and `arrWrEn` are low. Neither rises without an accepted byte load.
- R2: A byte load is a strobe in which `ceN` and `weN` are both low for at least GLITCH_MIN sampled clock edges. The address is sampled at the first edge on which both are low, which means the later of the two falling edges. The data is the value sampled on the last edge before either strobe returns high. The byte is stored at offset `addr[6:0]`.
- R3: When the same offset is loaded again during one load phase, the later value replaces the earlier one.
- R4: The array address is `{page, offset}`. The page is `addr[15:7]` of the last accepted byte.
- R5: An offset that was not loaded in the current operation is written to the array as FFh.
- R6: If no accepted strobe starts, `busy` rises on exactly the LOAD_TO-th clock edge after the edge at which the last accepted byte's strobe end is sampled.
- R7: During a load phase, a strobe that starts BYTE_WIN or more cycles after the last accepted byte is not loaded. It does not delay the timeout and does not change the page.
- R8: `busy` stays high for exactly WRITE_CYC cycles. Its last PAGE_BYTES cycles each carry one `arrWrEn` write, at offsets 0 to PAGE_BYTES-1 in ascending order.
- R9: Strobes that arrive while `busy` is high are ignored. They do not alter the page being written and do not start a later write.
- R10: A strobe during which `oeN` is sampled low, or that starts while `loadAllowed` is low, loads nothing.
- R11: A strobe that lasts fewer than GLITCH_MIN sampled edges loads nothing.
- R12: Every operation starts with an empty buffer, so bytes from an earlier operation never reach a later page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip select, active low, synchronized |
| weN | input | 1 | Write strobe, active low, synchronized |
| oeN | input | 1 | Output enable, active low; low inhibits loading |
| addr | input | 16 | Byte address: page in [15:7], offset in [6:0] |
| dataIn | input | 8 | Write data |
| loadAllowed | input | 1 | Qualifier from the command decoder |
| busy | output | 1 | Internal write in progress |
| arrWrEn | output | 1 | Array write strobe, one byte per cycle |
| arrWrAddr | output | 16 | Array write address |
| arrWrData | output | 8 | Array write data (FFh for unloaded offsets) |

## Verification
A corrupted valid mask or page register goes unseen during loading. It shows only in the streamed image, which begins WRITE_CYC-PAGE_BYTES cycles after the timeout, and there it appears as a stale byte, a missing FFh, or a whole page at the wrong address. A fault in the idle counter or in the window comparison appears sooner, as `busy` rising on the wrong edge. For that reason the timeout edge is checked to the exact cycle. A controller that fails to discard late, short, inhibited or in-write strobes leaves a stray byte in the next image or starts an unexpected second write. Each of these tests therefore runs long enough afterwards to watch for both outcomes.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_HOLD,
    ST_STREAM
  } pgwState_t;

  // events reported by the datapath strobe sampler
  typedef struct packed {
    logic rise;   // first edge with both strobes low
    logic fall;   // first edge after the strobe ended
    logic good;   // ended strobe was long enough and never inhibited
  } strobeEv_t;

  // strobes from control to datapath
  typedef struct packed {
    logic commit;    // store held byte into buffer
    logic clearAll;  // empty mask and page register
    logic streaming; // array port active
  } ctlStb_t;

endpackage

// File: rtl/pgw_datapath.sv
module pgw_datapath
  import pgw_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 128,
  parameter int GLITCH_MIN = 2,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  ctlStb_t           ctl,
  input  logic [OFF_W-1:0]  rdIdx,
  output strobeEv_t         ev,
  output logic [ADDR_W-1:0] arrWrAddr,
  output logic [DATA_W-1:0] arrWrData
);

  localparam int WID_W = $clog2(GLITCH_MIN + 1);
  localparam logic [WID_W-1:0] WID_MAX = WID_W'(GLITCH_MIN);

  logic              strobeNow;
  logic              strobeQ;
  logic [WID_W-1:0]  widthCnt;
  logic              oeBad;
  logic [ADDR_W-1:0] addrHold;
  logic [DATA_W-1:0] dataHold;
  logic [PAGE_BYTES-1:0]             validMask;
  logic [PAGE_W-1:0]                 pageReg;
  logic [PAGE_BYTES-1:0][DATA_W-1:0] bufFlat;
  logic [OFF_W-1:0]  holdOff;

  assign strobeNow = !ceN && !weN;
  assign holdOff   = addrHold[OFF_W-1:0];

  assign ev.rise = strobeNow && !strobeQ;
  assign ev.fall = !strobeNow && strobeQ;
  assign ev.good = (widthCnt == WID_MAX) && !oeBad;

  // strobe sampler: address at start, data on every low edge, width saturating
  always_ff @(posedge clk) begin
    if (!rstN) begin
      strobeQ  <= 1'b0;
      widthCnt <= '0;
      oeBad    <= 1'b0;
      addrHold <= '0;
      dataHold <= '0;
    end else begin
      strobeQ <= strobeNow;
      if (ev.rise) begin
        widthCnt <= WID_W'(1);
        oeBad    <= !oeN;
        addrHold <= addr;
        dataHold <= dataIn;
      end else if (strobeNow) begin
        if (widthCnt != WID_MAX) widthCnt <= widthCnt + WID_W'(1);
        oeBad    <= oeBad || !oeN;
        dataHold <= dataIn;
      end
    end
  end

  // page buffer, one register per byte
  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_byte
    logic [DATA_W-1:0] byteQ;
    always_ff @(posedge clk) begin
      if (ctl.commit && holdOff == OFF_W'(i)) byteQ <= dataHold;
    end
    assign bufFlat[i] = byteQ;
  end

  // valid mask and page register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validMask <= '0;
      pageReg   <= '0;
    end else if (ctl.clearAll) begin
      validMask <= '0;
      pageReg   <= '0;
    end else if (ctl.commit) begin
      validMask[holdOff] <= 1'b1;
      pageReg            <= addrHold[ADDR_W-1:OFF_W];
    end
  end

  assign arrWrAddr = {pageReg, rdIdx};
  assign arrWrData = validMask[rdIdx] ? bufFlat[rdIdx] : {DATA_W{1'b1}};

  // R11: a commit only ever follows a strobe end judged long enough
  p_commit_needs_width_r11: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |-> (ev.fall && ev.good));

  // R9: nothing is stored while the page is being streamed
  p_no_commit_in_stream_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.streaming |-> !ctl.commit);

  // R4: page address holds steady across consecutive array writes
  p_page_steady_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.streaming && $past(ctl.streaming)) |->
      arrWrAddr[ADDR_W-1:OFF_W] == $past(arrWrAddr[ADDR_W-1:OFF_W]));

endmodule

// File: rtl/pgw_control.sv
module pgw_control
  import pgw_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  parameter int BYTE_WIN   = 5000,
  parameter int LOAD_TO    = 10000,
  parameter int WRITE_CYC  = 250000,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int HOLD_CYC  = WRITE_CYC - PAGE_BYTES,
  localparam int CNT_W     = $clog2(LOAD_TO + 1),
  localparam int HLD_W     = $clog2(HOLD_CYC + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeEv_t        ev,
  input  logic             loadAllowed,
  output ctlStb_t          ctl,
  output logic [OFF_W-1:0] rdIdx,
  output logic             busy
);

  localparam logic [CNT_W-1:0] WIN_L  = CNT_W'(BYTE_WIN);
  localparam logic [CNT_W-1:0] TO_END = CNT_W'(LOAD_TO - 1);
  localparam logic [HLD_W-1:0] HOLD_END = HLD_W'(HOLD_CYC - 1);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PAGE_BYTES - 1);

  pgwState_t        state;
  logic [CNT_W-1:0] idleCnt;
  logic [HLD_W-1:0] holdCnt;
  logic             startOk;
  logic             windowOk;
  logic             acceptStart;

  assign windowOk    = (state == ST_IDLE) || (state == ST_LOAD && idleCnt < WIN_L);
  assign acceptStart = ev.rise && loadAllowed && windowOk;

  assign ctl.commit    = ev.fall && ev.good && startOk;
  assign ctl.streaming = (state == ST_STREAM);
  assign ctl.clearAll  = (state == ST_STREAM) && (rdIdx == LAST_OFF);
  assign busy          = (state == ST_HOLD) || (state == ST_STREAM);

  // whether the strobe in progress was accepted at its start
  always_ff @(posedge clk) begin
    if (!rstN)        startOk <= 1'b0;
    else if (ev.rise) startOk <= acceptStart;
    else if (ev.fall) startOk <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      idleCnt <= '0;
      holdCnt <= '0;
      rdIdx   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (ctl.commit) begin
            state   <= ST_LOAD;
            idleCnt <= '0;
          end
        end
        ST_LOAD: begin
          if (ctl.commit) begin
            idleCnt <= '0;
          end else if (startOk || acceptStart) begin
            idleCnt <= idleCnt;
          end else if (idleCnt == TO_END) begin
            state   <= ST_HOLD;
            holdCnt <= '0;
          end else begin
            idleCnt <= idleCnt + CNT_W'(1);
          end
        end
        ST_HOLD: begin
          if (holdCnt == HOLD_END) begin
            state <= ST_STREAM;
            rdIdx <= '0;
          end else begin
            holdCnt <= holdCnt + HLD_W'(1);
          end
        end
        ST_STREAM: begin
          if (rdIdx == LAST_OFF) state <= ST_IDLE;
          else                   rdIdx <= rdIdx + OFF_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: the internal write is only ever entered from the load phase
  p_write_from_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(state == ST_LOAD));

  // R7: a strobe starting outside the byte window is never accepted
  p_late_rejected_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD && ev.rise && idleCnt >= WIN_L) |=> !startOk);

  // R8: stream offsets step by one each cycle
  p_stream_ascends_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STREAM && $past(state == ST_STREAM)) |-> rdIdx == $past(rdIdx) + OFF_W'(1));

  // R9: no commit while the write is running
  p_busy_blocks_commit_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ctl.commit);

endmodule

// File: rtl/page_load_writer.sv
module page_load_writer
  import pgw_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 128,
  parameter int GLITCH_MIN = 2,
  parameter int BYTE_WIN   = 5000,
  parameter int LOAD_TO    = 10000,
  parameter int WRITE_CYC  = 250000,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              loadAllowed,
  output logic              busy,
  output logic              arrWrEn,
  output logic [ADDR_W-1:0] arrWrAddr,
  output logic [DATA_W-1:0] arrWrData
);

  strobeEv_t        ev;
  ctlStb_t          ctl;
  logic [OFF_W-1:0] rdIdx;

  pgw_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES), .GLITCH_MIN(GLITCH_MIN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .dataIn(dataIn), .ctl(ctl), .rdIdx(rdIdx),
    .ev(ev), .arrWrAddr(arrWrAddr), .arrWrData(arrWrData)
  );

  pgw_control #(
    .PAGE_BYTES(PAGE_BYTES), .BYTE_WIN(BYTE_WIN), .LOAD_TO(LOAD_TO), .WRITE_CYC(WRITE_CYC)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .ev(ev), .loadAllowed(loadAllowed),
    .ctl(ctl), .rdIdx(rdIdx), .busy(busy)
  );

  assign arrWrEn = ctl.streaming;

endmodule

// File: tb/tb_page_load_writer.sv
module tb_page_load_writer;

  localparam int BYTE_WIN  = 20;
  localparam int LOAD_TO   = 40;
  localparam int WRITE_CYC = 160;
  localparam int GMIN      = 2;
  localparam int PB        = 128;

  logic clk = 1'b0;
  logic rstN, ceN, weN, oeN, loadAllowed;
  logic [15:0] addr;
  logic [7:0]  dataIn;
  logic busy, arrWrEn;
  logic [15:0] arrWrAddr;
  logic [7:0]  arrWrData;

  always #10 clk = ~clk;

  page_load_writer #(
    .GLITCH_MIN(GMIN), .BYTE_WIN(BYTE_WIN), .LOAD_TO(LOAD_TO), .WRITE_CYC(WRITE_CYC)
  ) dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .dataIn(dataIn), .loadAllowed(loadAllowed),
    .busy(busy), .arrWrEn(arrWrEn), .arrWrAddr(arrWrAddr), .arrWrData(arrWrData)
  );

  int nChecks = 0;
  int nFails  = 0;

  // {endOp, ceLast, addr, data}
  localparam int NV = 7;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 1'b0, 16'h0180, 8'hA1},
    {1'b0, 1'b1, 16'h0185, 8'hB2},
    {1'b0, 1'b0, 16'h01FF, 8'h7E},
    {1'b1, 1'b1, 16'h0185, 8'hC3},
    {1'b0, 1'b0, 16'h0540, 8'h5A},
    {1'b1, 1'b0, 16'h0581, 8'h3C},
    {1'b1, 1'b1, 16'hFFFF, 8'h00}
  };

  // bench model
  logic [7:0] expBuf  [PB];
  logic       expMask [PB];
  logic [8:0] expPage;

  // captured array image
  logic [7:0] capImg [PB];
  logic [8:0] capPage;
  int capCnt, busyCnt;
  bit orderOk;

  always @(negedge clk) begin
    if (rstN && busy) busyCnt++;
    if (rstN && arrWrEn) begin
      if (int'(arrWrAddr[6:0]) != capCnt) orderOk = 1'b0;
      capImg[arrWrAddr[6:0]] = arrWrData;
      capPage = arrWrAddr[15:7];
      capCnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic beginOp();
    for (int i = 0; i < PB; i++) begin
      expMask[i] = 1'b0;
      expBuf[i]  = 8'h00;
      capImg[i]  = 8'h00;
    end
    capCnt  = 0;
    busyCnt = 0;
    orderOk = 1'b1;
    capPage = '0;
  endtask

  task automatic modelLoad(input logic [15:0] a, input logic [7:0] d);
    expMask[a[6:0]] = 1'b1;
    expBuf[a[6:0]]  = d;
    expPage         = a[15:7];
  endtask

  // ceLast: weN falls one cycle before ceN, with a wrong address on the bus
  task automatic loadByte(input logic [15:0] a, input logic [7:0] d, input int w, input bit ceLast);
    @(negedge clk);
    if (ceLast) begin
      weN = 1'b0; addr = ~a; dataIn = ~d;
      @(negedge clk);
    end
    ceN = 1'b0; weN = 1'b0; addr = a; dataIn = ~d;
    @(negedge clk);
    addr = ~a; dataIn = d;
    repeat (w - 1) @(negedge clk);
    ceN = 1'b1; weN = 1'b1;
  endtask

  task automatic waitWrite();
    bit seen = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (busy) seen = 1'b1;
      if (seen && !busy) break;
    end
  endtask

  task automatic checkImage(input string tagLoaded);
    chk(capCnt == PB, "R8", "array write count", capCnt, PB);
    chk(orderOk, "R8", "ascending offsets", int'(orderOk), 1);
    chk(busyCnt == WRITE_CYC, "R8", "busy length", busyCnt, WRITE_CYC);
    chk(capPage == expPage, "R4", "page", int'(capPage), int'(expPage));
    for (int i = 0; i < PB; i++) begin
      if (expMask[i]) chk(capImg[i] == expBuf[i], tagLoaded, "loaded byte", int'(capImg[i]), int'(expBuf[i]));
      else            chk(capImg[i] == 8'hFF, "R5", "unloaded byte", int'(capImg[i]), 8'hFF);
    end
  endtask

  task automatic expectQuiet(input string req);
    repeat (LOAD_TO + WRITE_CYC + 20) @(negedge clk);
    chk(busyCnt == 0, req, "busy cycles", busyCnt, 0);
    chk(capCnt == 0, req, "array writes", capCnt, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; ceN = 1'b1; weN = 1'b1; oeN = 1'b1; loadAllowed = 1'b1;
    addr = '0; dataIn = '0;
    beginOp();
    repeat (3) @(negedge clk);
    chk(!busy && !arrWrEn, "R1", "outputs in reset", int'({busy, arrWrEn}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !arrWrEn, "R1", "outputs after reset", int'({busy, arrWrEn}), 0);
    expectQuiet("R1");

    // table walk: R2 (both strobe orders), R3 overwrite, R4 last page, R6 exact timeout, R12
    beginOp();
    for (int v = 0; v < NV; v++) begin
      loadByte(VEC[v][23:8], VEC[v][7:0], 3, VEC[v][24]);
      modelLoad(VEC[v][23:8], VEC[v][7:0]);
      if (VEC[v][25]) begin
        repeat (LOAD_TO) @(negedge clk);
        chk(busy == 1'b0, "R6", "busy one edge before timeout", int'(busy), 0);
        @(negedge clk);
        chk(busy == 1'b1, "R6", "busy at timeout edge", int'(busy), 1);
        waitWrite();
        checkImage("R2 R3 R12");
        beginOp();
      end
    end

    // R7: late strobe ignored, page unchanged
    beginOp();
    loadByte(16'h0382, 8'h11, 3, 1'b0);
    modelLoad(16'h0382, 8'h11);
    repeat (BYTE_WIN + 3) @(negedge clk);
    loadByte(16'h0409, 8'h22, 3, 1'b0);
    waitWrite();
    checkImage("R7");

    // R11: short strobe inside a load phase leaves its offset FFh
    beginOp();
    loadByte(16'h0230, 8'h44, 3, 1'b0);
    modelLoad(16'h0230, 8'h44);
    loadByte(16'h0231, 8'h45, 1, 1'b0);
    waitWrite();
    checkImage("R11");

    // R11: short strobe from idle starts nothing
    beginOp();
    loadByte(16'h0600, 8'h66, 1, 1'b0);
    expectQuiet("R11");

    // R10: oeN low during strobe
    beginOp();
    oeN = 1'b0;
    loadByte(16'h0700, 8'h77, 3, 1'b0);
    oeN = 1'b1;
    expectQuiet("R10");

    // R10: loadAllowed low at strobe start
    beginOp();
    loadAllowed = 1'b0;
    loadByte(16'h0701, 8'h78, 3, 1'b0);
    loadAllowed = 1'b1;
    expectQuiet("R10");

    // R9: strobe during busy ignored, no second write follows
    beginOp();
    loadByte(16'h0110, 8'h99, 3, 1'b0);
    modelLoad(16'h0110, 8'h99);
    for (int i = 0; i < 200 && !busy; i++) @(negedge clk);
    loadByte(16'h0120, 8'h55, 3, 1'b0);
    waitWrite();
    checkImage("R9");
    beginOp();
    expectQuiet("R9");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule